// File: doc/BRIEF.md
# Burst Offset Sequencer

This block supplies the low address bits of a four-beat memory burst. A load strobe captures a starting offset taken from the low address bits of the access. Each later clock edge on which the active-low advance input is held low moves the offset to the next position in the burst order. The offset wraps within an aligned group of four addresses. The caller concatenates the offset with upper address bits that it registers itself. A completion flag rises once four beats have been presented.

Two orders are available, chosen by a static mode input. The linear order counts upward modulo four from the starting offset. The interleaved order, used for processor cache-line fills, presents the starting offset XOR the beat number. Decoding of the address strobes and storage of the upper address bits are handled outside this block. It sees only a load pulse and an advance input. It has no data stream, so every pin is a plain control or status signal with no handshake.

Top module: `burst_addr_ctr`

## Requirements
- R1: After reset, `ofs_o` is 0 and `done_o` is 0.
- R2: A clock edge with `load_i` high captures `start_i`. From the next cycle, `ofs_o` equals `start_i` and `done_o` is 0.
- R3: When `load_i` is high and `adv_n_i` is low on the same edge, the load wins. The offset becomes `start_i` and no step is taken.
- R4: An edge with `load_i` low and `adv_n_i` high leaves `ofs_o` and `done_o` unchanged.
- R5: With `mode_i` = 0 (linear), after n advances since the last load, `ofs_o` = (start + n) mod 4. The offset wraps from 3 to 0.
- R6: With `mode_i` = 1 (interleaved), after n advances since the last load, `ofs_o` = start XOR (n mod 4). For example, start 2 gives 2, 3, 0, 1 and start 1 gives 1, 0, 3, 2.
- R7: `done_o` goes high on the cycle after the third advance since the last load, which is the fourth beat. It stays high through further advances and holds until the next load. Further advances keep wrapping the offset.
- R8: Advances taken after reset with no load step from a start offset of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load pulse: capture the starting offset |
| start_i | input | 2 | Low address bits of the new access |
| adv_n_i | input | 1 | Active-low advance |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved; static during a burst |
| ofs_o | output | 2 | Current burst offset |
| done_o | output | 1 | Four beats have been presented since the last load |

## Verification
The hardest case to reach from the ports is one where several conditions line up at once. The offset must have wrapped past 3, the completion flag must already be saturated, and then a load must arrive on the same edge as an advance. The bench drives every start offset in both orders through six advances, with hold cycles mixed in. Each burst ends with a simultaneous load and advance. This exercises the wrap, the saturated flag and the load priority in one sequence, without relying on a chance alignment.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_tracker.sv
module burst_beat_tracker #(
  parameter int unsigned OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  output logic [OFS_W-1:0] idx_o,
  output logic             full_o
);
  localparam logic [OFS_W-1:0] LAST = {OFS_W{1'b1}};

  logic [OFS_W-1:0] idx_q;
  logic [OFS_W-1:0] cnt_q;

  // idx wraps with the burst; cnt saturates to mark completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (step_i) begin
      idx_q <= idx_q + 1'b1;
      if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign full_o = (cnt_q == LAST);
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int unsigned OFS_W = 2
) (
  input  logic [OFS_W-1:0] base_i,
  input  logic [OFS_W-1:0] idx_i,
  input  order_e           order_i,
  output logic [OFS_W-1:0] ofs_o
);
  logic [OFS_W-1:0] lin_ofs;
  logic [OFS_W-1:0] xor_ofs;

  assign lin_ofs = base_i + idx_i;

  for (genvar b = 0; b < OFS_W; b++) begin : g_bit
    assign xor_ofs[b] = base_i[b] ^ idx_i[b];
  end

  assign ofs_o = (order_i == ORD_INTERLEAVE) ? xor_ofs : lin_ofs;
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_pkg::*;
#(
  parameter int unsigned OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [OFS_W-1:0] start_i,
  input  logic             adv_n_i,
  input  logic             mode_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic             done_o
);
  logic [OFS_W-1:0] base_q;
  logic [OFS_W-1:0] idx;
  logic             step;
  order_e           order;

  assign step  = ~adv_n_i;
  assign order = order_e'(mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      base_q <= '0;
    else if (load_i) base_q <= start_i;
  end

  burst_beat_tracker #(.OFS_W(OFS_W)) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .step_i (step),
    .idx_o  (idx),
    .full_o (done_o)
  );

  burst_order_map #(.OFS_W(OFS_W)) u_map (
    .base_i  (base_q),
    .idx_i   (idx),
    .order_i (order),
    .ofs_o   (ofs_o)
  );
endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
  parameter int unsigned OFS_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic [OFS_W-1:0] start_i,
  input logic             adv_n_i,
  input logic             mode_i,
  input logic [OFS_W-1:0] ofs_o,
  input logic             done_o
);
  p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (mode_i != $past(mode_i)) || (ofs_o == $past(start_i)));

  p_load_clears_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !done_o);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_n_i) |=> ((mode_i != $past(mode_i)) || $stable(ofs_o)) && $stable(done_o));

  p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_n_i && !mode_i) |=> mode_i || (ofs_o == $past(ofs_o) + 1'b1));

  p_intlv_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_n_i && mode_i) |=> !mode_i || ($countones(ofs_o ^ $past(ofs_o)) >= 1));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> done_o);
endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.OFS_W(OFS_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load_i  (load_i),
  .start_i (start_i),
  .adv_n_i (adv_n_i),
  .mode_i  (mode_i),
  .ofs_o   (ofs_o),
  .done_o  (done_o)
);

// File: tb/burst_addr_ctr_test.sv
`timescale 1ns/1ps
module burst_addr_ctr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 1'b0;
  logic [1:0] start_i = 2'd0;
  logic       adv_n_i = 1'b1;
  logic       mode_i = 1'b0;
  logic [1:0] ofs_o;
  logic       done_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  burst_addr_ctr uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i),
    .adv_n_i(adv_n_i), .mode_i(mode_i), .ofs_o(ofs_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [1:0] exp_ofs, input logic exp_done);
    n_cmp++;
    if (ofs_o !== exp_ofs || done_o !== exp_done) begin
      n_bad++;
      $display("FAIL %s: ofs=%0d done=%0b expected ofs=%0d done=%0b",
               req, ofs_o, done_o, exp_ofs, exp_done);
    end
  endtask

  // drive at negedge, let one rising edge pass, sample 2 ns later
  task automatic cyc(input logic ld, input logic [1:0] st, input logic advn);
    @(negedge clk);
    load_i = ld; start_i = st; adv_n_i = advn;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [1:0] expect_ofs(input logic m, input int s, input int n);
    if (m) return 2'((s ^ (n % 4)) & 3);
    else   return 2'((s + n) % 4);
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #23;
    check("R1", 2'd0, 1'b0);
    rst_n = 1'b1;
    // R8: advance with no load steps from 0 (linear)
    cyc(1'b0, 2'd3, 1'b0);
    check("R8", 2'd1, 1'b0);
    cyc(1'b0, 2'd3, 1'b0);
    check("R8", 2'd2, 1'b0);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        mode_i = logic'(m);
        // R3: load together with advance; load wins
        cyc(1'b1, 2'(s), 1'b0);
        check("R3", 2'(s), 1'b0);
        check("R2", 2'(s), 1'b0);
        for (int n = 1; n <= 6; n++) begin
          cyc(1'b0, 2'(3 - s), 1'b0);
          check(m ? "R6" : "R5", expect_ofs(logic'(m), s, n), n >= 3);
          if (n == 3) check("R7", expect_ofs(logic'(m), s, n), 1'b1);
          if (n == 2 || n == 4) begin
            cyc(1'b0, 2'(s ^ 1), 1'b1);
            check("R4", expect_ofs(logic'(m), s, n), n >= 3);
          end
        end
      end
    end

    // plain load without advance, then hold
    cyc(1'b1, 2'd2, 1'b1);
    check("R2", 2'd2, 1'b0);
    cyc(1'b0, 2'd0, 1'b1);
    check("R4", 2'd2, 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule